// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single memory requests from a processor core into bus cycles on an external memory bus where the low address byte and the data byte share one 8-bit port. The high address byte goes out on a separate 8-bit port. Each external cycle has the same three phases. First, an address phase pulses the address strobe `ale` high while the low address is on the shared port, so an external latch can capture it. Second, a strobe phase pulls `rd_n` or `wr_n` low. Third, a hold phase keeps the high address and any write data on the bus after the strobe has ended.

The core side is a plain request/acknowledge pair. The core raises `req` with an address, a program-fetch flag, a write flag and write data, and keeps them steady until the block answers with a one-cycle `ack`. Read data comes back on `rdata` in the same cycle as `ack`. The level of `prog_ext_n` decides where program fetches go. When it is low, fetches run as external read cycles. When it is high, fetches are answered from the internal program store, with no bus activity. Data reads and data writes always use the external bus.

The shared port is split into an output byte, an output-enable and an input byte, so that the pad ring can build the bidirectional driver. The lengths of the address, strobe and hold phases are set in clock cycles by parameters. After reset the core begins execution at address 0040h. The package exports this value, but the bus sequencing does not depend on it.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs read: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `ack`=0.
- R2: An external cycle starts on the clock edge after `req` is seen. `ale` is then high for exactly ALE_CYC cycles. In each of those cycles `ad_oe`=1, `ad_out` equals `addr[7:0]` and `a_hi` equals `addr[15:8]`.
- R3: In an external read, `rd_n` goes low on the same edge that `ale` falls and stays low for exactly STB_CYC cycles. `ad_oe` is 0 for the whole time `rd_n` is low.
- R4: A read returns, on `rdata` together with `ack`, the value on `ad_in` at the clock edge where `rd_n` rises.
- R5: In an external write (`fetch`=0, `we`=1), `wr_n` is low for exactly STB_CYC cycles. The block drives `wdata` (`ad_oe`=1) from the fall of `ale` until HOLD_CYC cycles after `wr_n` rises, and then releases the port.
- R6: `a_hi` does not change from the rise of `ale` until `ack`. This covers the HOLD_CYC cycles after the strobe ends.
- R7: `ack` is high for exactly one cycle. For an external cycle, the number of cycles from `req` being seen to `ack` is 1+ALE_CYC+STB_CYC+HOLD_CYC. A `req` still held high in the `ack` cycle does not start another cycle.
- R8: A program fetch (`fetch`=1) runs as an external read when `prog_ext_n`=0. When `prog_ext_n`=1 it causes no `ale`, `rd_n` or `wr_n` activity, and `ack` arrives one cycle after `req` with `rdata` equal to `int_rdata`.
- R9: A data read (`fetch`=0, `we`=0) runs as an external read whatever the level of `prog_ext_n`.
- R10: `rd_n` and `wr_n` are never low at the same time. A fetch request with `we`=1 runs as a read and leaves `wr_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until ack |
| fetch | input | 1 | 1 = program fetch, 0 = data access |
| we | input | 1 | 1 = write (data accesses only) |
| addr | input | 16 | Request address |
| wdata | input | 8 | Write data |
| prog_ext_n | input | 1 | 0 = program fetches use the external bus |
| int_rdata | input | 8 | Byte from the internal program store |
| ack | output | 1 | One-cycle completion |
| rdata | output | 8 | Read data, valid with ack |
| ad_out | output | 8 | Shared port, output byte (low address or write data) |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, input byte |
| a_hi | output | 8 | High address port |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench sends program fetches with the select both low and high, so it can tell a cycle steered to the bus from one answered internally. It sends data reads with the select high, which shows that the select affects only fetches. Writes and a fetch that has the write flag set separate the two strobes and show whether the shared port is driven or released. The addresses used are 0040h, 0000h and FFFFh, plus patterns whose two bytes differ. An external memory model returns a value computed from the address, so a swapped or stale address byte shows up as wrong read data. Back-to-back requests check that the acknowledge cycle does not start a second cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] BOOT_ADDR = 16'h0040;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_STRB, ST_HOLD, ST_DONE
    } xbus_state_e;

    typedef enum logic [1:0] {
        K_INT_FETCH, K_EXT_READ, K_EXT_WRITE
    } xbus_kind_e;

    typedef struct packed {
        xbus_kind_e          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } xbus_cmd_t;

    // Fetches never write; fetches go internal when the select is high.
    function automatic xbus_kind_e classify(input logic is_fetch,
                                            input logic is_write,
                                            input logic ext_n);
        if (is_fetch)
            return ext_n ? K_INT_FETCH : K_EXT_READ;
        return is_write ? K_EXT_WRITE : K_EXT_READ;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
(
    input  logic              fetch,
    input  logic              we,
    input  logic              prog_ext_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output xbus_cmd_t         cmd
);
    always_comb begin
        cmd.kind  = classify(fetch, we, prog_ext_n);
        cmd.addr  = addr;
        cmd.wdata = wdata;
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ALE_CYC  = 2,
    parameter int STB_CYC  = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  xbus_cmd_t         cmd,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] int_rdata,
    output xbus_state_e       state,
    output xbus_cmd_t         cur,
    output logic [DATA_W-1:0] rdata
);
    localparam int MAXC = max3(ALE_CYC, STB_CYC, HOLD_CYC);
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] ALE_LAST  = CW'(ALE_CYC - 1);
    localparam logic [CW-1:0] STB_LAST  = CW'(STB_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;
    logic          phase_end;

    always_comb begin
        unique case (state)
            ST_ADDR: phase_end = (cnt == ALE_LAST);
            ST_STRB: phase_end = (cnt == STB_LAST);
            ST_HOLD: phase_end = (cnt == HOLD_LAST);
            default: phase_end = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
            rdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req) begin
                        cur <= cmd;
                        if (cmd.kind == K_INT_FETCH) begin
                            rdata <= int_rdata;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR, ST_STRB, ST_HOLD: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (state == ST_STRB && cur.kind == K_EXT_READ)
                            rdata <= ad_in;   // sampled as the read strobe rises
                        state <= (state == ST_ADDR) ? ST_STRB :
                                 (state == ST_STRB) ? ST_HOLD : ST_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  xbus_state_e       state,
    input  xbus_cmd_t         cur,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   a_hi
);
    logic is_wr;
    logic in_strobe;

    always_comb begin
        is_wr     = (cur.kind == K_EXT_WRITE);
        in_strobe = (state == ST_STRB);
        ale       = (state == ST_ADDR);
        rd_n      = !(in_strobe && !is_wr);
        wr_n      = !(in_strobe && is_wr);
        ad_oe     = ale || (is_wr && (state == ST_STRB || state == ST_HOLD));
        if (ale)
            ad_out = cur.addr[DATA_W-1:0];
        else if (is_wr)
            ad_out = cur.wdata;
        else
            ad_out = '0;
        a_hi      = cur.addr[ADDR_W-1:DATA_W];
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ALE_CYC  = 2,
    parameter int STB_CYC  = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              fetch,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prog_ext_n,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    xbus_cmd_t   cmd;
    xbus_cmd_t   cur;
    xbus_state_e state;

    xbus_decode u_decode (
        .fetch(fetch), .we(we), .prog_ext_n(prog_ext_n),
        .addr(addr), .wdata(wdata), .cmd(cmd)
    );

    xbus_seq #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst(rst), .req(req), .cmd(cmd),
        .ad_in(ad_in), .int_rdata(int_rdata),
        .state(state), .cur(cur), .rdata(rdata)
    );

    xbus_pins u_pins (
        .state(state), .cur(cur), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .a_hi(a_hi)
    );

    assign ack = (state == ST_DONE);
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic [7:0] ad_out,
    input logic [7:0] a_hi
);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    a_r3_bus_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    a_r5_data_driven: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);
    a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n && ad_oe));
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (ale && $past(ale)) |-> $stable(ad_out));
    a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    a_r6_ahi_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |=> $stable(a_hi));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ack(ack), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .a_hi(a_hi)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
    localparam int ALE_CYC  = 2;
    localparam int STB_CYC  = 2;
    localparam int HOLD_CYC = 1;
    localparam int EXT_LAT  = 1 + ALE_CYC + STB_CYC + HOLD_CYC;

    typedef struct {
        logic        ext;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  exp_rd;
    } item_t;

    logic clk = 0, rst = 1;
    logic req = 0, fetch = 0, we = 0, prog_ext_n = 1;
    logic [15:0] addr = 0;
    logic [7:0]  wdata = 0, int_rdata, ad_in, ad_out, rdata, a_hi;
    logic ack, ad_oe, ale, rd_n, wr_n;

    int tests = 0, fails = 0;
    item_t q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    logic [7:0] lat_lo = 0;
    always @(posedge clk) if (ale) lat_lo <= ad_out;
    assign ad_in     = !rd_n ? mem_fn({a_hi, lat_lo}) : 8'hEE;
    assign int_rdata = ~addr[7:0];

    xbus_ctrl #(.ALE_CYC(ALE_CYC), .STB_CYC(STB_CYC), .HOLD_CYC(HOLD_CYC)) u_dut (
        .clk(clk), .rst(rst), .req(req), .fetch(fetch), .we(we), .addr(addr),
        .wdata(wdata), .prog_ext_n(prog_ext_n), .int_rdata(int_rdata),
        .ack(ack), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor state
    int ale_len = 0, rd_len = 0, wr_len = 0, hold_len = 0, lat = 0;
    int rd_drive = 0, wr_undriven = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0]  bus_wdata = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (req && !ack) lat++;
            if (ale) begin
                ale_len++;
                bus_addr = {a_hi, ad_out};
                if (!ad_oe) rd_drive++;
            end
            if (!rd_n) begin
                rd_len++;
                if (ad_oe) rd_drive++;
            end
            if (!wr_n) begin
                wr_len++;
                bus_wdata = ad_out;
                if (!ad_oe) wr_undriven++;
            end
            if (wr_len > 0 && wr_n && ad_oe && !ale) hold_len++;
            if (ack) begin
                item_t it;
                if (q.size() == 0) begin
                    check("R7 unexpected ack", 1, 0);
                end else begin
                    it = q.pop_front();
                    check("R7 ack latency", lat, it.ext ? EXT_LAT : 1);
                    check("R8 R9 ale cycles", ale_len, it.ext ? ALE_CYC : 0);
                    check("R3 rd_n low cycles", rd_len, (it.ext && !it.wr) ? STB_CYC : 0);
                    check("R10 wr_n low cycles", wr_len, it.wr ? STB_CYC : 0);
                    check("R3 R2 port direction", rd_drive, 0);
                    if (it.ext) begin
                        check("R2 bus address", bus_addr, it.addr);
                        check("R6 a_hi held at ack", a_hi, it.addr[15:8]);
                    end
                    if (it.wr) begin
                        check("R5 write data", bus_wdata, it.wdata);
                        check("R5 write data hold", hold_len, HOLD_CYC);
                        check("R5 driven during wr_n", wr_undriven, 0);
                    end else begin
                        check("R4 R8 rdata", rdata, it.exp_rd);
                    end
                end
                ale_len = 0; rd_len = 0; wr_len = 0; hold_len = 0; lat = 0;
                rd_drive = 0; wr_undriven = 0;
            end else if (!req) begin
                check("R7 idle bus quiet", {ale, rd_n, wr_n}, 3'b011);
            end
        end
    end

    task automatic do_req(input logic f, input logic w, input logic sel_n,
                          input logic [15:0] a, input logic [7:0] d);
        item_t it;
        it.ext    = !(f && sel_n);
        it.wr     = w && !f;
        it.addr   = a;
        it.wdata  = d;
        it.exp_rd = it.ext ? mem_fn(a) : ~a[7:0];
        q.push_back(it);
        @(posedge clk); #1;
        fetch = f; we = w; prog_ext_n = sel_n; addr = a; wdata = d; req = 1;
        do @(negedge clk); while (!ack);
        @(posedge clk); #1;
        req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {ale, rd_n, wr_n, ad_oe, ack}, 5'b01100);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        check("R1 after reset", {ale, rd_n, wr_n, ad_oe, ack}, 5'b01100);
        do_req(1, 0, 0, 16'h0040, 8'h00);   // R8 external fetch at boot address
        do_req(1, 0, 1, 16'h0040, 8'h00);   // R8 internal fetch
        do_req(1, 0, 1, 16'h12F3, 8'h00);   // R8 internal fetch
        do_req(0, 0, 1, 16'hA55A, 8'h00);   // R9 data read, select high
        do_req(0, 0, 0, 16'h0000, 8'h00);   // R9 data read, select low
        do_req(0, 1, 1, 16'hFFFF, 8'hC3);   // R5 write
        do_req(0, 1, 0, 16'h3C81, 8'h7E);   // R5 write
        do_req(1, 1, 0, 16'h8001, 8'h99);   // R10 fetch with we: read
        do_req(1, 1, 1, 16'h8002, 8'h99);   // R10 internal fetch with we
        for (int i = 0; i < 4; i++)          // R7 back-to-back reads
            do_req(0, 0, 0, 16'h1111 * i + 16'h0102, 8'h00);
        repeat (4) @(negedge clk);
        check("R7 queue drained", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL R7 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule